// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block follows a control transfer on endpoint zero of a peripheral, one stage at a time. Its inputs are already-decoded events: a SETUP packet received, with the direction bit and a zero-length flag taken from that packet; completion of an IN token; completion of an OUT token; completion of the status handshake; and a clear strobe from software. It keeps a 3-bit stage code that can be read at all times. For every stage change that matters to firmware, it raises a one-cycle event pulse with a cause code.

The tracker moves from the setup stage into a read data, write data or no-data status stage. A token in the opposite direction moves it into the matching status stage. A status handshake in a status stage ends the transfer. A token that does not fit the current stage moves the tracker into a sequence-error stage. It stays there until a new SETUP arrives or software clears it. A SETUP in any stage restarts the sequence.

Top module: `ctrl_stage_tracker`

## Requirements
- R1: After reset the stage code is idle (0), evt_valid is 0 and evt_cause is 0.
- R2: A setup_evt in any stage sets the stage code to setup (1) one cycle later, with no event. This holds even when tokens or sw_clear are present in the same cycle.
- R3: One cycle after the stage code shows setup, the stage becomes no-data status (4) if the zero-length flag was set. Otherwise it becomes read data (2) if the captured direction bit was 1 (IN), or write data (3) if it was 0. An event with cause 1 (setup complete) is raised. Tokens that arrive while in setup are ignored.
- R4: In read data (2), out_done moves the stage to read status (5) with cause 3. A lone in_done leaves the stage at 2 and raises no event.
- R5: In write data (3), in_done moves the stage to write status (6) with cause 2. A lone out_done leaves the stage at 3 and raises no event.
- R6: status_done in stage 4, 5 or 6 moves the stage to idle (0) with cause 4 (transfer complete). The token of the status direction (in_done in 4 and 6, out_done in 5) is ignored in those stages.
- R7: A token that does not fit the current stage moves the stage to sequence-error (7) with cause 5. The misfits are: any token in idle; status_done or both data tokens in 2 or 3; out_done in 4 or 6; in_done in 5.
- R8: In sequence-error (7), tokens are ignored and no event is raised. sw_clear moves the stage to idle with no event. setup_evt moves it to setup.
- R9: sw_clear outside the sequence-error stage has no effect on the stage code and raises no event.
- R10: evt_valid is high for exactly one cycle, in the first cycle the stage code shows the new stage. While evt_valid is low, evt_cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_evt | input | 1 | SETUP packet received (one-cycle strobe) |
| setup_dir_in | input | 1 | Direction bit of the setup packet, 1 = IN (read) |
| setup_len_zero | input | 1 | Setup packet requests no data stage |
| in_done | input | 1 | IN token transaction completed |
| out_done | input | 1 | OUT token transaction completed |
| status_done | input | 1 | Status stage handshake completed |
| sw_clear | input | 1 | Software clear of the sequence-error stage |
| stage | output | 3 | Current stage code |
| evt_valid | output | 1 | One-cycle stage-transition pulse |
| evt_cause | output | 3 | Cause code of the transition |

## Verification
All state is held in one register set, and the stage code is an output, so a wrong next stage shows on `stage` at the next clock edge. A lost or stale direction capture shows one cycle after the setup stage, as the wrong data stage paired with cause 1. A misclassified token shows as a missing or spurious cause 5 in the same cycle that the stage changes. A sequence-error stage that leaks shows the first time a token or a clear is applied while it should be held.

// File: rtl/ctrl_stage_pkg.sv
package ctrl_stage_pkg;
    localparam int STAGE_W = 3;
    localparam int CAUSE_W = 3;

    typedef enum logic [STAGE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_RD_DATA = 3'd2,
        ST_WR_DATA = 3'd3,
        ST_ND_STS  = 3'd4,
        ST_RD_STS  = 3'd5,
        ST_WR_STS  = 3'd6,
        ST_SEQ_ERR = 3'd7
    } stage_e;

    typedef enum logic [CAUSE_W-1:0] {
        EV_NONE     = 3'd0,
        EV_SETUP_OK = 3'd1,
        EV_WR_STS   = 3'd2,
        EV_RD_STS   = 3'd3,
        EV_DONE     = 3'd4,
        EV_SEQ_ERR  = 3'd5
    } cause_e;

    typedef struct packed {
        stage_e stage;
        logic   dir_in;
        logic   len_zero;
        logic   evt;
        cause_e cause;
    } trk_state_t;

    typedef struct packed {
        logic adv;
        logic done;
        logic err;
    } tok_class_t;
endpackage

// File: rtl/ctrl_token_check.sv
module ctrl_token_check
    import ctrl_stage_pkg::*;
(
    input  stage_e     stage_i,
    input  logic       in_i,
    input  logic       out_i,
    input  logic       sts_i,
    output tok_class_t cls_o
);
    always_comb begin
        cls_o = '0;
        unique case (stage_i)
            ST_IDLE: begin
                cls_o.err = in_i | out_i | sts_i;
            end
            ST_RD_DATA: begin
                cls_o.err = sts_i | (in_i & out_i);
                cls_o.adv = out_i & ~cls_o.err;
            end
            ST_WR_DATA: begin
                cls_o.err = sts_i | (in_i & out_i);
                cls_o.adv = in_i & ~cls_o.err;
            end
            ST_ND_STS, ST_WR_STS: begin
                cls_o.err  = out_i;
                cls_o.done = sts_i & ~out_i;
            end
            ST_RD_STS: begin
                cls_o.err  = in_i;
                cls_o.done = sts_i & ~in_i;
            end
            default: cls_o = '0;
        endcase
    end
endmodule

// File: rtl/ctrl_stage_next.sv
module ctrl_stage_next
    import ctrl_stage_pkg::*;
(
    input  trk_state_t cur_i,
    input  tok_class_t cls_i,
    input  logic       setup_i,
    input  logic       dir_in_i,
    input  logic       len_zero_i,
    input  logic       clear_i,
    output trk_state_t nxt_o
);
    always_comb begin
        nxt_o       = cur_i;
        nxt_o.evt   = 1'b0;
        nxt_o.cause = EV_NONE;
        if (setup_i) begin
            nxt_o.stage    = ST_SETUP;
            nxt_o.dir_in   = dir_in_i;
            nxt_o.len_zero = len_zero_i;
        end else if (cur_i.stage == ST_SETUP) begin
            nxt_o.evt   = 1'b1;
            nxt_o.cause = EV_SETUP_OK;
            if (cur_i.len_zero)    nxt_o.stage = ST_ND_STS;
            else if (cur_i.dir_in) nxt_o.stage = ST_RD_DATA;
            else                   nxt_o.stage = ST_WR_DATA;
        end else if (cur_i.stage == ST_SEQ_ERR) begin
            if (clear_i) nxt_o.stage = ST_IDLE;
        end else if (cls_i.err) begin
            nxt_o.stage = ST_SEQ_ERR;
            nxt_o.evt   = 1'b1;
            nxt_o.cause = EV_SEQ_ERR;
        end else if (cls_i.adv) begin
            nxt_o.evt = 1'b1;
            if (cur_i.stage == ST_RD_DATA) begin
                nxt_o.stage = ST_RD_STS;
                nxt_o.cause = EV_RD_STS;
            end else begin
                nxt_o.stage = ST_WR_STS;
                nxt_o.cause = EV_WR_STS;
            end
        end else if (cls_i.done) begin
            nxt_o.stage = ST_IDLE;
            nxt_o.evt   = 1'b1;
            nxt_o.cause = EV_DONE;
        end
    end
endmodule

// File: rtl/ctrl_stage_tracker.sv
module ctrl_stage_tracker
    import ctrl_stage_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setup_evt,
    input  logic               setup_dir_in,
    input  logic               setup_len_zero,
    input  logic               in_done,
    input  logic               out_done,
    input  logic               status_done,
    input  logic               sw_clear,
    output logic [STAGE_W-1:0] stage,
    output logic               evt_valid,
    output logic [CAUSE_W-1:0] evt_cause
);
    trk_state_t state_d, state_q;
    tok_class_t tok_cls;

    ctrl_token_check u_tok (
        .stage_i (state_q.stage),
        .in_i    (in_done),
        .out_i   (out_done),
        .sts_i   (status_done),
        .cls_o   (tok_cls)
    );

    ctrl_stage_next u_next (
        .cur_i      (state_q),
        .cls_i      (tok_cls),
        .setup_i    (setup_evt),
        .dir_in_i   (setup_dir_in),
        .len_zero_i (setup_len_zero),
        .clear_i    (sw_clear),
        .nxt_o      (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{stage: ST_IDLE, dir_in: 1'b0, len_zero: 1'b0,
                         evt: 1'b0, cause: EV_NONE};
        end else begin
            state_q <= state_d;
        end
    end

    assign stage     = state_q.stage;
    assign evt_valid = state_q.evt;
    assign evt_cause = state_q.cause;
endmodule

// File: rtl/ctrl_stage_tracker_chk.sv
module ctrl_stage_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       setup_evt,
    input logic       in_done,
    input logic       out_done,
    input logic       status_done,
    input logic       sw_clear,
    input logic [2:0] stage,
    input logic       evt_valid,
    input logic [2:0] evt_cause
);
    // R2
    setup_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_evt |=> (stage == 3'd1 && !evt_valid));
    // R3
    setup_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd1 && !setup_evt) |=> (evt_valid && evt_cause == 3'd1));
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd7 && !setup_evt && !sw_clear) |=> (stage == 3'd7 && !evt_valid));
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_cause == 3'd4) |-> stage == 3'd0);
    // R7
    err_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_cause == 3'd5) |-> stage == 3'd7);
    // R10
    evt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> stage != $past(stage));
    // R10
    cause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> evt_cause == 3'd0);
    // R9
    clear_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !setup_evt && !in_done && !out_done && !status_done
         && stage != 3'd7 && stage != 3'd1) |=> $stable(stage));
endmodule

bind ctrl_stage_tracker ctrl_stage_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_evt   (setup_evt),
    .in_done     (in_done),
    .out_done    (out_done),
    .status_done (status_done),
    .sw_clear    (sw_clear),
    .stage       (stage),
    .evt_valid   (evt_valid),
    .evt_cause   (evt_cause)
);

// File: tb/test_ctrl_stage_tracker.sv
module test_ctrl_stage_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_evt = 0, setup_dir_in = 0, setup_len_zero = 0;
    logic in_done = 0, out_done = 0, status_done = 0, sw_clear = 0;
    logic [2:0] stage, evt_cause;
    logic       evt_valid;
    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ctrl_stage_tracker i_ctrl_stage_tracker (
        .clk(clk), .rst_n(rst_n), .setup_evt(setup_evt), .setup_dir_in(setup_dir_in),
        .setup_len_zero(setup_len_zero), .in_done(in_done), .out_done(out_done),
        .status_done(status_done), .sw_clear(sw_clear),
        .stage(stage), .evt_valid(evt_valid), .evt_cause(evt_cause)
    );

    // inputs set at a falling edge, sampled at the rising edge, checked at the next falling edge
    task automatic step(input bit su, input bit dir, input bit zl, input bit i,
                        input bit o, input bit s, input bit c);
        setup_evt = su; setup_dir_in = dir; setup_len_zero = zl;
        in_done = i; out_done = o; status_done = s; sw_clear = c;
        @(negedge clk);
    endtask

    task automatic idle();                   step(0,0,0,0,0,0,0); endtask
    task automatic tok(input bit i, input bit o, input bit s); step(0,0,0,i,o,s,0); endtask

    task automatic chk(input string tag, input logic [2:0] st, input logic ev, input logic [2:0] ca);
        n_chk++;
        if (stage !== st || evt_valid !== ev || evt_cause !== ca) begin
            n_err++;
            $display("FAIL %s: stage=%0d evt=%0d cause=%0d expected stage=%0d evt=%0d cause=%0d",
                     tag, stage, evt_valid, evt_cause, st, ev, ca);
        end
    endtask

    task automatic open_xfer(input bit dir, input bit zl, input logic [2:0] data_st);
        step(1, dir, zl, 0, 0, 0, 0);
        chk("R2", 3'd1, 0, 0);
        idle();
        chk("R3", data_st, 1, 3'd1);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1", 3'd0, 0, 0);
        rst_n = 1;
        idle();
        chk("R1", 3'd0, 0, 0);
    endtask

    task automatic t_read();
        open_xfer(1, 0, 3'd2);
        tok(1,0,0); chk("R4", 3'd2, 0, 0);
        tok(0,1,0); chk("R4", 3'd5, 1, 3'd3);
        tok(0,1,0); chk("R6", 3'd5, 0, 0);
        tok(0,0,1); chk("R6", 3'd0, 1, 3'd4);
        idle();     chk("R10", 3'd0, 0, 0);
    endtask

    task automatic t_write();
        open_xfer(0, 0, 3'd3);
        tok(0,1,0); chk("R5", 3'd3, 0, 0);
        tok(1,0,0); chk("R5", 3'd6, 1, 3'd2);
        idle();     chk("R10", 3'd6, 0, 0);
        tok(1,0,0); chk("R6", 3'd6, 0, 0);
        tok(0,0,1); chk("R6", 3'd0, 1, 3'd4);
    endtask

    task automatic t_nodata();
        open_xfer(1, 1, 3'd4);
        tok(1,0,0); chk("R6", 3'd4, 0, 0);
        tok(0,0,1); chk("R6", 3'd0, 1, 3'd4);
    endtask

    task automatic t_seq_err();
        tok(1,0,0); chk("R7", 3'd7, 1, 3'd5);
        step(0,0,0,0,0,0,1); chk("R8", 3'd0, 0, 0);
        open_xfer(1, 0, 3'd2);
        tok(0,0,1); chk("R7", 3'd7, 1, 3'd5);
        open_xfer(0, 0, 3'd3);
        tok(1,1,0); chk("R7", 3'd7, 1, 3'd5);
        open_xfer(0, 1, 3'd4);
        tok(0,1,0); chk("R7", 3'd7, 1, 3'd5);
        open_xfer(1, 0, 3'd2);
        tok(0,1,0); chk("R4", 3'd5, 1, 3'd3);
        tok(1,0,0); chk("R7", 3'd7, 1, 3'd5);
        open_xfer(0, 0, 3'd3);
        tok(1,0,0); chk("R5", 3'd6, 1, 3'd2);
        tok(0,1,0); chk("R7", 3'd7, 1, 3'd5);
    endtask

    task automatic t_err_hold();
        tok(1,0,0); chk("R8", 3'd7, 0, 0);
        tok(0,1,0); chk("R8", 3'd7, 0, 0);
        tok(0,0,1); chk("R8", 3'd7, 0, 0);
        idle();     chk("R8", 3'd7, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0); chk("R8", 3'd1, 0, 0);
        idle();     chk("R3", 3'd2, 1, 3'd1);
    endtask

    task automatic t_restart();
        step(1, 0, 0, 0, 1, 0, 1); chk("R2", 3'd1, 0, 0);
        step(0, 0, 0, 1, 1, 1, 0); chk("R3", 3'd3, 1, 3'd1);
        tok(0,1,0); chk("R5", 3'd3, 0, 0);
    endtask

    task automatic t_clear_noop();
        step(0,0,0,0,0,0,1); chk("R9", 3'd3, 0, 0);
        tok(1,0,0);          chk("R5", 3'd6, 1, 3'd2);
        tok(0,0,1);          chk("R6", 3'd0, 1, 3'd4);
        step(0,0,0,0,0,0,1); chk("R9", 3'd0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_read();
        t_write();
        t_nodata();
        t_seq_err();
        t_err_hold();
        t_restart();
        t_clear_noop();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule